// File: doc/BRIEF.md
# CHIP-8 Instruction Pre-Decoder

This block sits between instruction fetch and the microcode store of a CHIP-8 processor. The fetch sequence presents the instruction one byte at a time on a shared byte input. A high-byte load strobe is asserted in the first fetch step, and a low-byte load strobe in the second. The two bytes are held in internal latches. From the latched 16-bit word the block derives a dense 6-bit class code that indexes the microcode, and it also splits out the operand fields that the datapath uses.

The top nibble selects the instruction family. For some families the remaining twelve bits are pure operands. For others, the low nibble or the low byte picks the sub-operation. The block reduces all of this to one class number per supported instruction. Every unsupported pattern maps to a single reserved code. The field outputs are always driven from the latched word, whatever the class.

Top module: `c8_predecode`

## Requirements
- R1: While reset is asserted, and until the first byte load after it, both latches hold zero. The class output is 63 (the invalid code) and every field output is zero.
- R2: A cycle with `load_hi` high captures `byte_in` as word bits 15:8 at that clock edge. A cycle with only `load_lo` high captures it as bits 7:0. When both strobes are high, only the high byte is written and the low byte keeps its value.
- R3: In a cycle with neither strobe high, the latched word and every output stay unchanged, whatever `byte_in` does.
- R4: For every word, the field outputs are x = bits 11:8, y = bits 7:4, n = bits 3:0, kk = bits 7:0 and nnn = bits 11:0.
- R5: Families whose low bits are all operands map by top nibble alone: 1→2, 2→3, 3→4, 4→5, 6→7, 7→8, A→19, B→20, C→21.
- R6: In family 8, a low nibble N from 0 to 7 gives class 9+N, and N=E gives 17. Any other N gives 63.
- R7: In family 0, word 00E0 gives 0 and word 00EE gives 1, and everything else gives 63. Family 5 gives 6 and family 9 gives 18 when the low nibble is 0, and 63 otherwise.
- R8: In family E, low byte 9E gives 23 and A1 gives 24. In family F, the low bytes map as follows: 07→25, 0A→26, 15→27, 18→28, 1E→29, 29→30, 33→31, 55→32, 65→33. Any other low byte in either family gives 63.
- R9: Family D always gives 22, for every low nibble, because there n is a sprite byte count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_hi | input | 1 | Capture byte_in as the high instruction byte |
| load_lo | input | 1 | Capture byte_in as the low instruction byte |
| byte_in | input | 8 | Fetched instruction byte |
| class_o | output | 6 | Instruction class code (63 = invalid) |
| x_o | output | 4 | First register index |
| y_o | output | 4 | Second register index |
| n_o | output | 4 | Low nibble |
| kk_o | output | 8 | Low byte immediate |
| nnn_o | output | 12 | 12-bit address |

## Verification
The outputs are combinational from the two latches, so a wrong latch value shows up on `nnn_o` or `kk_o` on the clock edge that wrote it. A wrong sub-operation decode shows up on `class_o` at that same edge. Sweeping every high byte against every low byte exposes any misdecoded opcode pattern in the cycle after its low byte is loaded. A strobe that writes the wrong lane, or writes when it should not, appears one cycle later as a field that differs from the bytes that were sent.

// File: rtl/c8_pd_pkg.sv
package c8_pd_pkg;
  localparam int CLASS_W = 6;
  typedef logic [CLASS_W-1:0] class_t;

  localparam class_t C_CLS    = 6'd0;
  localparam class_t C_RET    = 6'd1;
  localparam class_t C_JMP    = 6'd2;
  localparam class_t C_CALL   = 6'd3;
  localparam class_t C_SEQI   = 6'd4;
  localparam class_t C_SNEI   = 6'd5;
  localparam class_t C_SEQR   = 6'd6;
  localparam class_t C_MOVI   = 6'd7;
  localparam class_t C_ADDI   = 6'd8;
  localparam class_t C_ALU0   = 6'd9;
  localparam class_t C_SHLF   = 6'd17;
  localparam class_t C_SNER   = 6'd18;
  localparam class_t C_SETIX  = 6'd19;
  localparam class_t C_JMPOFS = 6'd20;
  localparam class_t C_RAND   = 6'd21;
  localparam class_t C_DRAW   = 6'd22;
  localparam class_t C_KEYEQ  = 6'd23;
  localparam class_t C_KEYNE  = 6'd24;
  localparam class_t C_F07    = 6'd25;
  localparam class_t C_F0A    = 6'd26;
  localparam class_t C_F15    = 6'd27;
  localparam class_t C_F18    = 6'd28;
  localparam class_t C_F1E    = 6'd29;
  localparam class_t C_F29    = 6'd30;
  localparam class_t C_F33    = 6'd31;
  localparam class_t C_F55    = 6'd32;
  localparam class_t C_F65    = 6'd33;
  localparam class_t C_BAD    = 6'd63;
endpackage

// File: rtl/c8_pd_byte_reg.sv
module c8_pd_byte_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/c8_pd_fields.sv
module c8_pd_fields #(
  parameter int NIB_W = 4
) (
  input  logic [4*NIB_W-1:0] word,
  output logic [NIB_W-1:0]   x,
  output logic [NIB_W-1:0]   y,
  output logic [NIB_W-1:0]   n,
  output logic [2*NIB_W-1:0] kk,
  output logic [3*NIB_W-1:0] nnn
);
  assign n   = word[NIB_W-1:0];
  assign y   = word[2*NIB_W-1:NIB_W];
  assign x   = word[3*NIB_W-1:2*NIB_W];
  assign kk  = word[2*NIB_W-1:0];
  assign nnn = word[3*NIB_W-1:0];
endmodule

// File: rtl/c8_pd_classify.sv
module c8_pd_classify
  import c8_pd_pkg::*;
(
  input  logic [15:0] word,
  output class_t      cls
);
  logic [3:0] fam;
  logic [3:0] low_nib;
  logic [7:0] low_byte;

  assign fam      = word[15:12];
  assign low_nib  = word[3:0];
  assign low_byte = word[7:0];

  always_comb begin
    cls = C_BAD;
    unique case (fam)
      4'h0: begin
        if (word[11:0] == 12'h0E0)      cls = C_CLS;
        else if (word[11:0] == 12'h0EE) cls = C_RET;
      end
      4'h1: cls = C_JMP;
      4'h2: cls = C_CALL;
      4'h3: cls = C_SEQI;
      4'h4: cls = C_SNEI;
      4'h5: if (low_nib == 4'h0) cls = C_SEQR;
      4'h6: cls = C_MOVI;
      4'h7: cls = C_ADDI;
      4'h8: begin
        if (!low_nib[3])           cls = C_ALU0 + class_t'(low_nib);
        else if (low_nib == 4'hE)  cls = C_SHLF;
      end
      4'h9: if (low_nib == 4'h0) cls = C_SNER;
      4'hA: cls = C_SETIX;
      4'hB: cls = C_JMPOFS;
      4'hC: cls = C_RAND;
      4'hD: cls = C_DRAW;
      4'hE: begin
        if (low_byte == 8'h9E)      cls = C_KEYEQ;
        else if (low_byte == 8'hA1) cls = C_KEYNE;
      end
      4'hF: begin
        case (low_byte)
          8'h07:   cls = C_F07;
          8'h0A:   cls = C_F0A;
          8'h15:   cls = C_F15;
          8'h18:   cls = C_F18;
          8'h1E:   cls = C_F1E;
          8'h29:   cls = C_F29;
          8'h33:   cls = C_F33;
          8'h55:   cls = C_F55;
          8'h65:   cls = C_F65;
          default: cls = C_BAD;
        endcase
      end
      default: cls = C_BAD;
    endcase
  end
endmodule

// File: rtl/c8_predecode.sv
module c8_predecode
  import c8_pd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_hi,
  input  logic                load_lo,
  input  logic [BYTE_W-1:0]   byte_in,
  output logic [CLASS_W-1:0]  class_o,
  output logic [BYTE_W/2-1:0] x_o,
  output logic [BYTE_W/2-1:0] y_o,
  output logic [BYTE_W/2-1:0] n_o,
  output logic [BYTE_W-1:0]   kk_o,
  output logic [3*BYTE_W/2-1:0] nnn_o
);
  localparam int LANES  = 2;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int NIB_W  = BYTE_W / 2;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [LANES-1:0]  lane_en;
  logic [WORD_W-1:0] word;
  class_t            cls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign lane_en[1] = load_hi;
  assign lane_en[0] = load_lo & ~load_hi;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    c8_pd_byte_reg #(.W(BYTE_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en    (lane_en[i]),
      .d     (byte_in),
      .q     (word[i*BYTE_W +: BYTE_W])
    );
  end

  c8_pd_fields #(.NIB_W(NIB_W)) u_fields (
    .word (word),
    .x    (x_o),
    .y    (y_o),
    .n    (n_o),
    .kk   (kk_o),
    .nnn  (nnn_o)
  );

  c8_pd_classify u_cls (
    .word (word),
    .cls  (cls)
  );

  assign class_o = cls;
endmodule

// File: rtl/c8_predecode_chk.sv
module c8_predecode_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        load_hi,
  input logic        load_lo,
  input logic [7:0]  byte_in,
  input logic [5:0]  class_o,
  input logic [3:0]  x_o,
  input logic [3:0]  n_o,
  input logic [7:0]  kk_o,
  input logic [11:0] nnn_o
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_ok)
    (!load_hi && !load_lo) |=> ($stable(class_o) && $stable(nnn_o)));

  assert_lo_capture_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    (load_lo && !load_hi) |=> (kk_o == $past(byte_in) && $stable(x_o)));

  assert_hi_capture_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    load_hi |=> (x_o == $past(byte_in[3:0]) && $stable(kk_o)));

  assert_class_range_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    (class_o <= 6'd33 || class_o == 6'd63));

  assert_alu_sub_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (class_o >= 6'd9 && class_o <= 6'd16) |-> (n_o == 4'(class_o - 6'd9)));
endmodule

bind c8_predecode c8_predecode_chk u_chk (
  .clk     (clk),
  .rst_ok  (rst_sync_n),
  .load_hi (load_hi),
  .load_lo (load_lo),
  .byte_in (byte_in),
  .class_o (class_o),
  .x_o     (x_o),
  .n_o     (n_o),
  .kk_o    (kk_o),
  .nnn_o   (nnn_o)
);

// File: tb/c8_predecode_test.sv
module c8_predecode_test;
  logic        clk;
  logic        rst_n;
  logic        load_hi;
  logic        load_lo;
  logic [7:0]  byte_in;
  logic [5:0]  class_o;
  logic [3:0]  x_o, y_o, n_o;
  logic [7:0]  kk_o;
  logic [11:0] nnn_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  c8_predecode uut (
    .clk(clk), .rst_n(rst_n), .load_hi(load_hi), .load_lo(load_lo),
    .byte_in(byte_in), .class_o(class_o), .x_o(x_o), .y_o(y_o),
    .n_o(n_o), .kk_o(kk_o), .nnn_o(nnn_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 180000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 180000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int expect_class(input logic [15:0] w);
    int f  = int'(w[15:12]);
    int nb = int'(w[3:0]);
    int lb = int'(w[7:0]);
    case (f)
      0:  return (w == 16'h00E0) ? 0 : (w == 16'h00EE) ? 1 : 63;  // R7
      1:  return 2;  2: return 3;  3: return 4;  4: return 5;     // R5
      5:  return (nb == 0) ? 6 : 63;                             // R7
      6:  return 7;  7: return 8;
      8:  return (nb < 8) ? 9 + nb : (nb == 14) ? 17 : 63;       // R6
      9:  return (nb == 0) ? 18 : 63;
      10: return 19; 11: return 20; 12: return 21;
      13: return 22;                                             // R9
      14: return (lb == 'h9E) ? 23 : (lb == 'hA1) ? 24 : 63;     // R8
      default: begin
        case (lb)
          'h07: return 25; 'h0A: return 26; 'h15: return 27;
          'h18: return 28; 'h1E: return 29; 'h29: return 30;
          'h33: return 31; 'h55: return 32; 'h65: return 33;
          default: return 63;
        endcase
      end
    endcase
  endfunction

  function automatic string class_tag(input logic [3:0] f);
    case (f)
      4'h0, 4'h5, 4'h9: return "R7";
      4'h8:             return "R6";
      4'hD:             return "R9";
      4'hE, 4'hF:       return "R8";
      default:          return "R5";
    endcase
  endfunction

  task automatic check_word(input logic [15:0] w, input string ftag);
    int ec = expect_class(w);
    checks = checks + 1;
    if (int'(class_o) != ec) begin
      errors = errors + 1;
      $display("FAIL %s class for %h: actual %0d expected %0d", class_tag(w[15:12]), w, class_o, ec);
    end
    checks = checks + 1;
    if (x_o != w[11:8] || y_o != w[7:4] || n_o != w[3:0] || kk_o != w[7:0] || nnn_o != w[11:0]) begin
      errors = errors + 1;
      $display("FAIL %s fields for %h: actual x=%h y=%h n=%h kk=%h nnn=%h expected %h",
               ftag, w, x_o, y_o, n_o, kk_o, nnn_o, w);
    end
  endtask

  task automatic push(input logic hi, input logic lo, input logic [7:0] b);
    @(negedge clk);
    load_hi = hi; load_lo = lo; byte_in = b;
    @(negedge clk);
    load_hi = 1'b0; load_lo = 1'b0;
  endtask

  initial begin
    load_hi = 1'b0; load_lo = 1'b0; byte_in = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_word(16'h0000, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_word(16'h0000, "R1");

    // R2: both strobes high writes only the high byte
    push(1'b1, 1'b0, 8'h8A);
    push(1'b0, 1'b1, 8'h34);
    check_word(16'h8A34, "R2");
    push(1'b1, 1'b1, 8'hD5);
    check_word(16'hD534, "R2");

    // R3: byte_in toggling without strobes changes nothing
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      byte_in = 8'(k * 8'h47 + 8'h11);
    end
    @(negedge clk);
    check_word(16'hD534, "R3");

    // R4 with R5..R9: exhaustive sweep of every word
    for (int h = 0; h < 256; h++) begin
      push(1'b1, 1'b0, 8'(h));
      for (int l = 0; l < 256; l++) begin
        push(1'b0, 1'b1, 8'(l));
        check_word({8'(h), 8'(l)}, "R4");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule